// File: doc/BRIEF.md
# Upward-Growing Stack Operation Sequencer

This block carries out one stack operation at a time against a byte-wide memory port. A caller presents an operation code with the current values of a data register, a stack-pointer register and the program counter, and pulses `start`. The sequencer then steps through the memory bytes the operation needs, one byte per cycle. It raises `done` for one cycle, and in that cycle the updated data register, stack pointer and program counter are valid, together with a flag saying whether the program counter must be reloaded.

The stack grows toward higher addresses. Pushes store little-endian at the pointer and then advance it. Pops read at the pointer and then step it back. A data pop also wipes the bytes it consumed: it reads every byte first and then writes zeros over the same bytes, so the value returned is never disturbed by the clearing. Program-counter saves and restores, calls and returns reuse the same byte machinery with the full register width. The memory answers a read in the same cycle it is asked.

Top module: `stk_seq`

## Requirements
- R1: Op code 0 (full push) writes the `XLEN/8` bytes of `reg_data` at addresses `reg_sp`, `reg_sp+1`, … with the least significant byte first. The returned pointer is `reg_sp + XLEN/8`.
- R2: Op codes 1, 2 and 3 push only the low 1, 2 or 4 bytes of `reg_data`, in the same little-endian order, and return `reg_sp` plus 1, 2 or 4.
- R3: Op codes 4 to 10 (pops) first read their bytes in ascending address order starting at `reg_sp`. Only after every read do they write zero to the same addresses in the same order. The returned pointer is `reg_sp` minus the access size: full width for code 4, 1 byte for codes 5 and 6, 2 bytes for codes 7 and 8, 4 bytes for codes 9 and 10.
- R4: The odd pop codes 5, 7 and 9 sign-extend the value read into `data_out`. The even codes 6, 8 and 10 zero-extend it. Code 4 returns the full-width value.
- R5: Op code 11 writes `reg_pc` little-endian at `reg_sp` and returns `reg_sp + XLEN/8`. Op code 12 reads a full-width value at `reg_sp` into `pc_out`, returns `reg_sp - XLEN/8` and leaves memory unchanged. Both assert `pc_load` in the done cycle only for code 12.
- R6: Op code 13 (call) writes `reg_pc` at `reg_sp`, returns `reg_sp + XLEN/8`, sets `pc_out` to `reg_data` and asserts `pc_load` in the done cycle.
- R7: Op code 14 (return) reads a full-width value at `reg_sp` into `pc_out`, returns `reg_sp - XLEN/8`, asserts `pc_load` and writes nothing to memory.
- R8: `busy` rises the cycle after an accepted `start`. Each memory access takes one cycle. `done` is high for exactly one cycle, right after the last access, and `busy` falls after it. A `start` seen while `busy` is high is ignored.
- R9: During and right after reset, `busy`, `done`, `mem_req` and `pc_load` are low, and `data_out`, `sp_out` and `pc_out` are zero.
- R10: Op code 15 makes no memory access. It raises `done` in the cycle after acceptance with `sp_out = reg_sp`, `pc_out = reg_pc` and `pc_load` low.
- R11: For every op code other than 4 to 10, `data_out` equals `reg_data`. `pc_out` equals `reg_pc` unless R5, R6 or R7 replace it. The outputs hold their values between done cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| op | input | 4 | Operation code, see requirements |
| reg_data | input | XLEN | Data register value (call target for code 13) |
| reg_sp | input | XLEN | Stack-pointer register value |
| reg_pc | input | XLEN | Current program counter |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse, results valid |
| data_out | output | XLEN | Updated data register value |
| sp_out | output | XLEN | Updated stack-pointer value |
| pc_out | output | XLEN | New program counter value |
| pc_load | output | 1 | Program counter must be reloaded from `pc_out` (done cycle only) |
| mem_req | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | XLEN | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the same cycle as the request |

## Verification
Two things can land in one cycle here: a fresh `start` request and a sequence that is still in flight, including its done cycle. The bench provokes this by raising `start` with a different op code and pointer during the first byte of a four-byte push. The cycle-by-cycle model then demands the exact byte trace and results of the push alone, followed by an idle port. A second overlap lives inside the pops: the read phase and the clearing phase touch the same addresses. The model requires all reads to come before any zero write, and it checks both the extended value and the wiped memory afterwards.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [3:0] {
        OP_PUSH_R  = 4'd0,
        OP_PUSH_B  = 4'd1,
        OP_PUSH_H  = 4'd2,
        OP_PUSH_W  = 4'd3,
        OP_POP_R   = 4'd4,
        OP_POP_BS  = 4'd5,
        OP_POP_BU  = 4'd6,
        OP_POP_HS  = 4'd7,
        OP_POP_HU  = 4'd8,
        OP_POP_WS  = 4'd9,
        OP_POP_WU  = 4'd10,
        OP_SAVE_PC = 4'd11,
        OP_LOAD_PC = 4'd12,
        OP_CALL    = 4'd13,
        OP_RET     = 4'd14,
        OP_NONE    = 4'd15
    } stk_op_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_PUSH,
        K_POP,
        K_SAVEPC,
        K_LOADPC,
        K_CALL,
        K_RET
    } stk_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR,
        S_RD,
        S_CLR,
        S_FIN
    } stk_state_e;

endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
    import stk_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN / 8) + 1
) (
    input  stk_op_e         op,
    output stk_kind_e       kind,
    output logic [CW-1:0]   nbytes,
    output logic            sext
);
    localparam int RB = XLEN / 8;

    always_comb begin
        kind   = K_NONE;
        nbytes = CW'(RB);
        sext   = 1'b0;
        case (op)
            OP_PUSH_R:  kind = K_PUSH;
            OP_PUSH_B:  begin kind = K_PUSH; nbytes = CW'(1); end
            OP_PUSH_H:  begin kind = K_PUSH; nbytes = CW'(2); end
            OP_PUSH_W:  begin kind = K_PUSH; nbytes = CW'(4); end
            OP_POP_R:   kind = K_POP;
            OP_POP_BS:  begin kind = K_POP; nbytes = CW'(1); sext = 1'b1; end
            OP_POP_BU:  begin kind = K_POP; nbytes = CW'(1); end
            OP_POP_HS:  begin kind = K_POP; nbytes = CW'(2); sext = 1'b1; end
            OP_POP_HU:  begin kind = K_POP; nbytes = CW'(2); end
            OP_POP_WS:  begin kind = K_POP; nbytes = CW'(4); sext = 1'b1; end
            OP_POP_WU:  begin kind = K_POP; nbytes = CW'(4); end
            OP_SAVE_PC: kind = K_SAVEPC;
            OP_LOAD_PC: kind = K_LOADPC;
            OP_CALL:    kind = K_CALL;
            OP_RET:     kind = K_RET;
            default:    kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/stk_extend.sv
module stk_extend #(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN / 8) + 1
) (
    input  logic [XLEN-1:0] raw,
    input  logic [CW-1:0]   nbytes,
    input  logic            sext,
    output logic [XLEN-1:0] val
);
    localparam int RB = XLEN / 8;
    localparam int IW = $clog2(XLEN);

    logic [XLEN-1:0] mask;
    logic [IW-1:0]   msb_pos;
    int              top;

    always_comb begin
        top = 8 * int'(nbytes) - 1;
        if (top < 0) begin
            top = 0;
        end
        msb_pos = IW'(top);
        if (int'(nbytes) >= RB) begin
            mask = '1;
        end else begin
            mask = (XLEN'(1) << (8 * int'(nbytes))) - XLEN'(1);
        end
        val = raw & mask;
        if (sext && raw[msb_pos]) begin
            val = val | ~mask;
        end
    end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] reg_data,
    input  logic [XLEN-1:0] reg_sp,
    input  logic [XLEN-1:0] reg_pc,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] data_out,
    output logic [XLEN-1:0] sp_out,
    output logic [XLEN-1:0] pc_out,
    output logic            pc_load,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata
);
    localparam int RB = XLEN / 8;
    localparam int CW = $clog2(RB) + 1;

    typedef struct packed {
        stk_state_e      st;
        stk_kind_e       kind;
        logic [CW-1:0]   nb;
        logic            sx;
        logic [CW-1:0]   idx;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] dat;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] rbuf;
        logic [XLEN-1:0] r_sp;
        logic [XLEN-1:0] r_dat;
        logic [XLEN-1:0] r_pc;
        logic            r_pl;
    } seq_t;

    seq_t q, d;

    stk_kind_e       dec_kind;
    logic [CW-1:0]   dec_nb;
    logic            dec_sx;
    logic [XLEN-1:0] rd_word;
    logic [XLEN-1:0] ext_val;
    logic [XLEN-1:0] wr_src;
    logic            last;

    stk_op_decode #(.XLEN(XLEN), .CW(CW)) u_dec (
        .op     (stk_op_e'(op)),
        .kind   (dec_kind),
        .nbytes (dec_nb),
        .sext   (dec_sx)
    );

    // Read buffer with the byte arriving this cycle merged in.
    always_comb begin
        rd_word = q.rbuf;
        if (q.st == S_RD) begin
            rd_word[8*q.idx +: 8] = mem_rdata;
        end
    end

    stk_extend #(.XLEN(XLEN), .CW(CW)) u_ext (
        .raw    (rd_word),
        .nbytes (q.nb),
        .sext   (q.sx),
        .val    (ext_val)
    );

    assign last   = (q.idx == q.nb - CW'(1));
    assign wr_src = (q.kind == K_PUSH) ? q.dat : q.pc;

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.sp + XLEN'(q.idx);
        mem_wdata = 8'h00;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.kind = dec_kind;
                    d.nb   = dec_nb;
                    d.sx   = dec_sx;
                    d.idx  = '0;
                    d.sp   = reg_sp;
                    d.dat  = reg_data;
                    d.pc   = reg_pc;
                    d.rbuf = '0;
                    case (dec_kind)
                        K_PUSH, K_SAVEPC, K_CALL: d.st = S_WR;
                        K_POP, K_LOADPC, K_RET:   d.st = S_RD;
                        default:                  d.st = S_FIN;
                    endcase
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wr_src[8*q.idx +: 8];
                if (last) begin
                    d.st = S_FIN;
                end else begin
                    d.idx = q.idx + CW'(1);
                end
            end
            S_RD: begin
                mem_req = 1'b1;
                d.rbuf  = rd_word;
                if (last) begin
                    if (q.kind == K_POP) begin
                        d.st  = S_CLR;
                        d.idx = '0;
                    end else begin
                        d.st = S_FIN;
                    end
                end else begin
                    d.idx = q.idx + CW'(1);
                end
            end
            S_CLR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = 8'h00;
                if (last) begin
                    d.st = S_FIN;
                end else begin
                    d.idx = q.idx + CW'(1);
                end
            end
            S_FIN: begin
                d.st = S_IDLE;
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase

        // Results are formed on entry to the done cycle.
        if (d.st == S_FIN && q.st != S_FIN) begin
            case (d.kind)
                K_PUSH, K_SAVEPC, K_CALL: d.r_sp = d.sp + XLEN'(d.nb);
                K_POP, K_LOADPC, K_RET:   d.r_sp = d.sp - XLEN'(d.nb);
                default:                  d.r_sp = d.sp;
            endcase
            d.r_dat = (d.kind == K_POP) ? ext_val : d.dat;
            case (d.kind)
                K_LOADPC, K_RET: d.r_pc = rd_word;
                K_CALL:          d.r_pc = d.dat;
                default:         d.r_pc = d.pc;
            endcase
            d.r_pl = (d.kind == K_LOADPC) || (d.kind == K_RET) || (d.kind == K_CALL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = (q.st == S_FIN);
    assign data_out = q.r_dat;
    assign sp_out   = q.r_sp;
    assign pc_out   = q.r_pc;
    assign pc_load  = done && q.r_pl;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic [XLEN-1:0] sp_out,
    input logic            pc_load
);

    p_req_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_sp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(sp_out));

    p_pcload_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> done);

endmodule

bind stk_seq stk_seq_chk #(.XLEN(XLEN)) u_stk_seq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mem_req (mem_req),
    .sp_out  (sp_out),
    .pc_load (pc_load)
);

// File: tb/stk_seq_bench.sv
`timescale 1ns/1ps
module stk_seq_bench;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [3:0]      op = 4'd0;
    logic [XLEN-1:0] reg_data = '0, reg_sp = '0, reg_pc = '0;
    logic            busy, done, pc_load, mem_req, mem_we;
    logic [XLEN-1:0] data_out, sp_out, pc_out, mem_addr;
    logic [7:0]      mem_wdata, mem_rdata;
    logic [7:0]      mem [0:255];

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    stk_seq #(.XLEN(XLEN)) u_stk_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .reg_data(reg_data), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .busy(busy), .done(done), .data_out(data_out), .sp_out(sp_out),
        .pc_out(pc_out), .pc_load(pc_load), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            mem[8'(a + i)] = v[8*i +: 8];
        end
    endtask

    // Reference model: builds the expected byte trace and results, then
    // compares the port against it on every clock of the operation.
    task automatic run_op(input logic [3:0] o, input logic [31:0] dv,
                          input logic [31:0] s, input logic [31:0] p,
                          input bit poke);
        int n; int kind; bit sx; string tg; string dtg;
        logic [31:0] v, mask, src, e_sp, e_dat, e_pc; bit e_pl;
        int ta[$]; bit tw[$]; logic [7:0] td[$];
        n = 4; kind = 0; sx = 0;
        case (o)
            4'd0:  begin kind = 1; tg = "R1"; end
            4'd1:  begin kind = 1; n = 1; tg = "R2"; end
            4'd2:  begin kind = 1; n = 2; tg = "R2"; end
            4'd3:  begin kind = 1; tg = "R2"; end
            4'd4:  begin kind = 2; tg = "R3"; end
            4'd5:  begin kind = 2; n = 1; sx = 1; tg = "R3"; end
            4'd6:  begin kind = 2; n = 1; tg = "R3"; end
            4'd7:  begin kind = 2; n = 2; sx = 1; tg = "R3"; end
            4'd8:  begin kind = 2; n = 2; tg = "R3"; end
            4'd9:  begin kind = 2; sx = 1; tg = "R3"; end
            4'd10: begin kind = 2; tg = "R3"; end
            4'd11: begin kind = 3; tg = "R5"; end
            4'd12: begin kind = 4; tg = "R5"; end
            4'd13: begin kind = 5; tg = "R6"; end
            4'd14: begin kind = 6; tg = "R7"; end
            default: begin kind = 0; n = 0; tg = "R10"; end
        endcase
        dtg = (kind == 2) ? "R4" : "R11";
        v = 0;
        for (int i = 0; i < n; i++) begin
            v = v | (32'(mem[8'(s + i)]) << (8 * i));
        end
        if (n < 4) begin
            mask = (32'd1 << (8 * n)) - 32'd1;
            v = v & mask;
            if (sx && v[8*n-1]) v = v | ~mask;
        end
        src = (kind == 1) ? dv : p;
        e_sp = s; e_dat = dv; e_pc = p; e_pl = 0;
        if (kind == 1 || kind == 3 || kind == 5) begin
            for (int i = 0; i < n; i++) begin
                ta.push_back(int'(s) + i); tw.push_back(1'b1); td.push_back(src[8*i +: 8]);
            end
            e_sp = s + n;
        end
        if (kind == 2 || kind == 4 || kind == 6) begin
            for (int i = 0; i < n; i++) begin
                ta.push_back(int'(s) + i); tw.push_back(1'b0); td.push_back(8'h00);
            end
            e_sp = s - n;
        end
        if (kind == 2) begin
            for (int i = 0; i < n; i++) begin
                ta.push_back(int'(s) + i); tw.push_back(1'b1); td.push_back(8'h00);
            end
            e_dat = v;
        end
        if (kind == 4 || kind == 6) begin e_pc = v; e_pl = 1; end
        if (kind == 5) begin e_pc = dv; e_pl = 1; end

        @(negedge clk);
        op = o; reg_data = dv; reg_sp = s; reg_pc = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < ta.size(); i++) begin
            if (poke && i == 0) begin
                start = 1'b1; op = 4'd4; reg_sp = 32'h80;   // R8: must be ignored
            end
            if (poke && i == 1) start = 1'b0;
            chk(mem_req && !done, poke ? "R8" : tg, "access request", {31'd0, mem_req}, 32'd1);
            chk(mem_we == tw[i], tg, "access direction", {31'd0, mem_we}, {31'd0, tw[i]});
            chk(mem_addr == 32'(ta[i]), tg, "access address", mem_addr, 32'(ta[i]));
            if (tw[i]) chk(mem_wdata == td[i], tg, "write byte", {24'd0, mem_wdata}, {24'd0, td[i]});
            @(negedge clk);
        end
        start = 1'b0;
        chk(done === 1'b1, "R8", "done after last access", {31'd0, done}, 32'd1);
        chk(mem_req === 1'b0, "R8", "no access in done cycle", {31'd0, mem_req}, 32'd0);
        chk(sp_out == e_sp, tg, "pointer", sp_out, e_sp);
        chk(data_out == e_dat, dtg, "data result", data_out, e_dat);
        chk(pc_out == e_pc, (kind >= 4) ? tg : "R11", "pc result", pc_out, e_pc);
        chk(pc_load == e_pl, tg, "pc load flag", {31'd0, pc_load}, {31'd0, e_pl});
        if (kind == 2) begin
            for (int i = 0; i < n; i++) begin
                chk(mem[8'(s + i)] == 8'h00, "R3", "slot cleared", {24'd0, mem[8'(s + i)]}, 32'd0);
            end
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8", "single done pulse",
            {30'd0, busy, done}, 32'd0);
        chk(sp_out == e_sp, "R11", "pointer held", sp_out, e_sp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && pc_load === 1'b0,
            "R9", "control in reset", {28'd0, busy, done, mem_req, pc_load}, 32'd0);
        chk(sp_out === '0 && data_out === '0 && pc_out === '0, "R9", "results in reset",
            sp_out | data_out | pc_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && sp_out === '0, "R9", "idle after reset", {31'd0, busy}, 32'd0);

        run_op(4'd0, 32'hA1B2C3D4, 32'h10, 32'h400, 0);
        chk(mem[8'h13] == 8'hA1, "R1", "top byte stored", {24'd0, mem[8'h13]}, 32'hA1);
        run_op(4'd1, 32'h11223344, 32'h20, 32'h400, 0);
        chk(mem[8'h21] == 8'hEE, "R2", "byte push stays narrow", {24'd0, mem[8'h21]}, 32'hEE);
        run_op(4'd2, 32'h55667788, 32'h30, 32'h400, 0);
        run_op(4'd3, 32'h99AABBCC, 32'h34, 32'h400, 0);
        run_op(4'd4, 32'h0, 32'h10, 32'h400, 0);

        preload(32'h40, 32'h9C12F385); run_op(4'd5,  32'h1, 32'h40, 32'h0, 0);
        preload(32'h40, 32'h9C12F385); run_op(4'd6,  32'h1, 32'h40, 32'h0, 0);
        preload(32'h40, 32'h9C12F385); run_op(4'd7,  32'h1, 32'h40, 32'h0, 0);
        preload(32'h40, 32'h9C12F385); run_op(4'd8,  32'h1, 32'h40, 32'h0, 0);
        preload(32'h40, 32'h9C12F385); run_op(4'd9,  32'h1, 32'h40, 32'h0, 0);
        preload(32'h40, 32'h9C12F385); run_op(4'd10, 32'h1, 32'h40, 32'h0, 0);
        preload(32'h44, 32'h0000707F); run_op(4'd5,  32'h1, 32'h44, 32'h0, 0);
        preload(32'h44, 32'h0000707F); run_op(4'd7,  32'h1, 32'h44, 32'h0, 0);

        run_op(4'd11, 32'h5, 32'h50, 32'hDEADBEEF, 0);
        run_op(4'd12, 32'h5, 32'h50, 32'h0, 0);
        chk(mem[8'h50] == 8'hEF, "R5", "pc restore leaves memory", {24'd0, mem[8'h50]}, 32'hEF);
        run_op(4'd13, 32'h00001234, 32'h60, 32'h00000100, 0);
        run_op(4'd14, 32'h7, 32'h60, 32'h0, 0);
        chk(mem[8'h60] == 8'h00 && mem[8'h61] == 8'h01, "R7", "return leaves memory",
            {16'd0, mem[8'h61], mem[8'h60]}, 32'h0100);
        run_op(4'd15, 32'hCAFE0001, 32'h70, 32'h200, 0);
        run_op(4'd0, 32'h01020304, 32'h90, 32'h0, 1);
        chk(mem[8'h80] == 8'hEE, "R8", "ignored start left memory", {24'd0, mem[8'h80]}, 32'hEE);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule